// File: doc/BRIEF.md
# Valid-Gated Datapath Pipeline with Gating-Efficiency Accounting

This block is a fixed-depth datapath pipeline whose per-stage data registers are written only when the stage has real work to do. Every stage carries a word and a valid flag. It exports one load-enable per stage as a port, so the enables stand in for clock-gate controls and can be observed directly. New words enter when the upstream side raises its valid. A stall from the downstream consumer freezes the last stage. That stall then backs up only across stages that hold valid words, so bubbles further up are squeezed out while the tail is blocked.

A configuration input chooses how a blocked stage keeps its word. In recirculate mode the stage is still enabled and writes its own contents back. In gated mode the stall also drops the enable, so the blocked bank is not written at all.

Two saturating counters run alongside the pipeline. One counts enabled stage-cycles. The other counts every possible stage-cycle. On request, a small bit-serial divider turns their ratio into an integer efficiency percentage, equal to the share of stage-cycles that were not enabled.

Top module: `vgate_pipe`

## Requirements
- R1: After reset every stage is empty: out_valid is 0, in_ready is 1, stage_en is 0 while in_valid is 0, both counters are 0 and eff_pct is 0.
- R2: With ds_stall low, a word accepted on one clock edge appears on out_data with out_valid high after DEPTH edges (3 further edges beyond the loading edge for DEPTH=4), and words leave in the order they entered.
- R3: stage_en bit i (bit 0 = input stage, bit DEPTH-1 = output stage) is high only when stage i is loading a valid word from its upstream neighbour, or when it is blocked in recirculate mode; an empty upstream with no block gives 0.
- R4: While stage i is blocked, its word and valid flag do not change; out_data and out_valid stay stable while out_valid and ds_stall are both high.
- R5: A stall reaches stage i only if stage i and every stage below it hold valid words; in_ready is 0 only when all stages are valid and ds_stall is high, and a word fed behind a blocked tail moves up until it is next to the blocked run.
- R6: With stall_gates=1 a blocked stage has stage_en=0; with stall_gates=0 a blocked stage has stage_en=1.
- R7: Each clock edge without clear adds DEPTH to tot_cnt and the number of set stage_en bits to en_cnt; both counters saturate at 2^CNT_W-1 and never wrap.
- R8: cnt_clr high at a clock edge makes both counters 0 after that edge, taking priority over counting.
- R9: eff_req while idle captures the counters, raises eff_busy, and later pulses eff_done for one cycle with eff_pct = floor(100*(tot-en)/tot) of the captured values, or 0 when the captured tot is 0; eff_req while busy is ignored.
- R10: A stage whose upstream is empty does not load data, so out_data keeps the last valid word when out_valid falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream word present |
| in_data | input | WIDTH | Upstream word |
| in_ready | output | 1 | Input stage can accept this cycle |
| ds_stall | input | 1 | Downstream cannot take the output word |
| out_valid | output | 1 | Output stage holds a valid word |
| out_data | output | WIDTH | Output stage word |
| stall_gates | input | 1 | 1: blocked stages lose their enable; 0: they recirculate |
| stage_en | output | DEPTH | Per-stage data register load enable |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| en_cnt | output | CNT_W | Enabled stage-cycles, saturating |
| tot_cnt | output | CNT_W | Possible stage-cycles, saturating |
| eff_req | input | 1 | Start an efficiency computation |
| eff_busy | output | 1 | Division in progress |
| eff_done | output | 1 | One-cycle pulse when eff_pct is updated |
| eff_pct | output | 7 | Gating efficiency in percent, 0 to 100 |

## Verification
A wrong valid flag inside the pipeline shows within DEPTH cycles: a lost flag drops a word from the output sequence, and a stuck flag either repeats an old word or lowers in_ready when the pipe is not full. A wrong block chain shows on the same cycle as an unexpected stage_en value, or as out_data changing under ds_stall. Counter faults show as exact mismatches against counts worked out from known feed patterns. A divider fault shows only at eff_done, about CNT_W+7 cycles after a request.

// File: rtl/vgp_pkg.sv
// Package: shared constants and types for the valid-gated pipeline.
// Assumes: efficiency is an integer percentage that fits in PCT_W bits.
package vgp_pkg;
    localparam int PCT_W     = 7;
    localparam int PCT_SCALE = 100;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/vgp_hold_chain.sv
// vgp_hold_chain: works out which stages are blocked this cycle.
// A stage is blocked when it holds a valid word and the stage after it
// (or the downstream consumer, for the last stage) is blocked.
// Assumes: vld bit 0 is the input stage, bit DEPTH-1 the output stage.
module vgp_hold_chain #(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] vld,
    input  logic             ds_stall,
    output logic [DEPTH-1:0] hold
);
    // Walk from the output stage toward the input stage.
    always_comb begin
        logic carry;
        carry = ds_stall;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            carry   = vld[i] & carry;
            hold[i] = carry;
        end
    end
endmodule

// File: rtl/vgp_stage.sv
// vgp_stage: one pipeline stage with a gated data bank and a valid flag.
// The data bank writes only when en is high; the valid flag is a single
// bit updated whenever the stage is not blocked.
// Assumes: hold is only high when this stage's valid flag is high.
module vgp_stage #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic [WIDTH-1:0] up_data,
    input  logic             hold,
    input  logic             stall_gates,
    output logic             vld,
    output logic [WIDTH-1:0] data,
    output logic             en
);
    logic [WIDTH-1:0] next_data;

    // Enable: load from upstream when free, recirculate when blocked and not gated.
    always_comb begin
        if (hold) begin
            en        = !stall_gates;
            next_data = data;
        end else begin
            en        = up_valid;
            next_data = up_data;
        end
    end

    // Valid flag follows upstream unless blocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld <= 1'b0;
        else if (!hold)
            vld <= up_valid;
    end

    // Data bank written only under its enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (en)
            data <= next_data;
    end
endmodule

// File: rtl/vgp_gate_counters.sv
// vgp_gate_counters: saturating accumulators of enabled and possible
// stage-cycles. Clear has priority over counting.
// Assumes: DEPTH fits comfortably below 2^CNT_W.
module vgp_gate_counters #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] stage_en,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] en_cnt,
    output logic [CNT_W-1:0] tot_cnt
);
    localparam int POP_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [POP_W-1:0] pop;
    logic [CNT_W:0]   en_sum;
    logic [CNT_W:0]   tot_sum;

    // Number of stages enabled this cycle.
    always_comb begin
        pop = '0;
        for (int i = 0; i < DEPTH; i++)
            pop = pop + POP_W'(stage_en[i]);
    end

    // Widened sums expose the carry used for saturation.
    always_comb begin
        en_sum  = {1'b0, en_cnt} + (CNT_W + 1)'(pop);
        tot_sum = {1'b0, tot_cnt} + (CNT_W + 1)'(DEPTH);
    end

    // Accumulate with saturation; clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) begin
            en_cnt  <= '0;
            tot_cnt <= '0;
        end else begin
            en_cnt  <= en_sum[CNT_W]  ? CNT_MAX : en_sum[CNT_W-1:0];
            tot_cnt <= tot_sum[CNT_W] ? CNT_MAX : tot_sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/vgp_eff_divider.sv
// vgp_eff_divider: bit-serial restoring divider producing
// floor(100*(tot-en)/tot), one quotient bit per cycle.
// Assumes: en <= tot; a zero denominator yields 0 after one cycle.
module vgp_eff_divider
    import vgp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] en_cnt,
    input  logic [CNT_W-1:0] tot_cnt,
    output logic             busy,
    output logic             done,
    output logic [PCT_W-1:0] pct
);
    localparam int NB    = CNT_W + PCT_W;
    localparam int STEPW = $clog2(NB + 1);

    div_state_e       state;
    logic [NB-1:0]    quo;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] den;
    logic [STEPW-1:0] steps;
    logic [CNT_W-1:0] diff;
    logic [NB-1:0]    numer;
    logic [CNT_W:0]   trial;
    logic             fits;

    // Numerator from the live counters, clamped at zero.
    always_comb begin
        diff  = (tot_cnt >= en_cnt) ? (tot_cnt - en_cnt) : '0;
        numer = NB'(diff) * NB'(PCT_SCALE);
    end

    // One restoring step: shift in the next numerator bit and compare.
    always_comb begin
        trial = {rem, quo[NB-1]};
        fits  = trial >= {1'b0, den};
    end

    // Control and datapath of the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DIV_IDLE;
            quo   <= '0;
            rem   <= '0;
            den   <= '0;
            steps <= '0;
            done  <= 1'b0;
            pct   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                DIV_IDLE: begin
                    if (req) begin
                        if (tot_cnt == '0) begin
                            pct  <= '0;
                            done <= 1'b1;
                        end else begin
                            quo   <= numer;
                            rem   <= '0;
                            den   <= tot_cnt;
                            steps <= STEPW'(NB);
                            state <= DIV_RUN;
                        end
                    end
                end
                DIV_RUN: begin
                    rem   <= fits ? CNT_W'(trial - {1'b0, den}) : trial[CNT_W-1:0];
                    quo   <= {quo[NB-2:0], fits};
                    steps <= steps - 1'b1;
                    if (steps == STEPW'(1)) begin
                        pct   <= {quo[PCT_W-2:0], fits};
                        done  <= 1'b1;
                        state <= DIV_IDLE;
                    end
                end
                default: state <= DIV_IDLE;
            endcase
        end
    end

    assign busy = (state == DIV_RUN);
endmodule

// File: rtl/vgate_pipe.sv
// vgate_pipe: DEPTH-stage valid-gated pipeline with exported per-stage
// load enables, saturating stage-cycle counters and an efficiency divider.
// Assumes: the downstream consumer takes out_data on any cycle where
// out_valid is high and ds_stall is low; upstream holds in_data while
// in_ready is low.
module vgate_pipe
    import vgp_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ready,
    input  logic             ds_stall,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    input  logic             stall_gates,
    output logic [DEPTH-1:0] stage_en,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] en_cnt,
    output logic [CNT_W-1:0] tot_cnt,
    input  logic             eff_req,
    output logic             eff_busy,
    output logic             eff_done,
    output logic [PCT_W-1:0] eff_pct
);
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] hold;
    logic [WIDTH-1:0] sdata [DEPTH];

    vgp_hold_chain #(.DEPTH(DEPTH)) u_hold (
        .vld      (vld),
        .ds_stall (ds_stall),
        .hold     (hold)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic             up_v;
        logic [WIDTH-1:0] up_d;
        if (i == 0) begin : g_head
            assign up_v = in_valid;
            assign up_d = in_data;
        end else begin : g_body
            assign up_v = vld[i-1];
            assign up_d = sdata[i-1];
        end
        vgp_stage #(.WIDTH(WIDTH)) u_stage (
            .clk         (clk),
            .rst_n       (rst_n),
            .up_valid    (up_v),
            .up_data     (up_d),
            .hold        (hold[i]),
            .stall_gates (stall_gates),
            .vld         (vld[i]),
            .data        (sdata[i]),
            .en          (stage_en[i])
        );
    end

    assign in_ready  = !hold[0];
    assign out_valid = vld[DEPTH-1];
    assign out_data  = sdata[DEPTH-1];

    vgp_gate_counters #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_en (stage_en),
        .cnt_clr  (cnt_clr),
        .en_cnt   (en_cnt),
        .tot_cnt  (tot_cnt)
    );

    vgp_eff_divider #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (eff_req),
        .en_cnt  (en_cnt),
        .tot_cnt (tot_cnt),
        .busy    (eff_busy),
        .done    (eff_done),
        .pct     (eff_pct)
    );
endmodule

// File: rtl/vgate_pipe_chk.sv
// vgate_pipe_chk: port-level properties of vgate_pipe, attached by bind.
module vgate_pipe_chk #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             ds_stall,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_data,
    input logic             stall_gates,
    input logic [DEPTH-1:0] stage_en,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] en_cnt,
    input logic [CNT_W-1:0] tot_cnt,
    input logic             eff_done,
    input logic [6:0]       eff_pct
);
    // R3: in gated mode the input stage is only enabled by a valid upstream word.
    p_head_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_gates && stage_en[0]) |-> in_valid);

    // R4: a blocked output word stays put.
    p_held_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ds_stall) |=> (out_valid && $stable(out_data)));

    // R5: input is refused only when the tail is stalled and occupied.
    p_refuse_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && ds_stall));

    // R6: blocked output stage enable follows the gating mode.
    p_gated_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_gates && out_valid && ds_stall) |-> !stage_en[DEPTH-1]);
    p_recirc_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_gates && out_valid && ds_stall) |-> stage_en[DEPTH-1]);

    // R7: counters never wrap downward and enabled never exceeds possible.
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (tot_cnt >= $past(tot_cnt)) && (en_cnt >= $past(en_cnt)));
    p_en_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_cnt <= tot_cnt);

    // R8: clear empties both counters.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (tot_cnt == '0) && (en_cnt == '0));

    // R9: done is a single-cycle pulse and the result is a valid percentage.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eff_done |=> !eff_done);
    p_pct_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eff_pct <= 7'd100);

    // R10: the output word is not overwritten when the output empties.
    p_no_bubble_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $stable(out_data));
endmodule

bind vgate_pipe vgate_pipe_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .ds_stall    (ds_stall),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .stall_gates (stall_gates),
    .stage_en    (stage_en),
    .cnt_clr     (cnt_clr),
    .en_cnt      (en_cnt),
    .tot_cnt     (tot_cnt),
    .eff_done    (eff_done),
    .eff_pct     (eff_pct)
);

// File: tb/tb_vgate_pipe.sv
// tb_vgate_pipe: table-driven flow test, then directed stall, counter,
// divider, saturation and reset tests for vgate_pipe.
module tb_vgate_pipe;
    localparam int CLK_P  = 10;
    localparam int DEPTH  = 4;
    localparam int WIDTH  = 32;
    localparam int CNT_W  = 12;
    localparam int WD_CYC = 150000;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // Row: {in_valid, in_byte, exp_out_valid, exp_out_byte}
    localparam int NROW = 12;
    localparam logic [17:0] FLOW [NROW] = '{
        {1'b1, 8'h10, 1'b0, 8'h00},
        {1'b1, 8'h11, 1'b0, 8'h00},
        {1'b0, 8'h12, 1'b0, 8'h00},
        {1'b1, 8'h13, 1'b1, 8'h10},
        {1'b0, 8'h14, 1'b1, 8'h11},
        {1'b0, 8'h15, 1'b0, 8'h11},
        {1'b1, 8'h16, 1'b1, 8'h13},
        {1'b1, 8'h17, 1'b0, 8'h13},
        {1'b1, 8'h18, 1'b0, 8'h13},
        {1'b0, 8'h19, 1'b1, 8'h16},
        {1'b0, 8'h1A, 1'b1, 8'h17},
        {1'b0, 8'h1B, 1'b1, 8'h18}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic             in_ready;
    logic             ds_stall = 1'b0;
    logic             out_valid;
    logic [WIDTH-1:0] out_data;
    logic             stall_gates = 1'b0;
    logic [DEPTH-1:0] stage_en;
    logic             cnt_clr = 1'b0;
    logic [CNT_W-1:0] en_cnt;
    logic [CNT_W-1:0] tot_cnt;
    logic             eff_req = 1'b0;
    logic             eff_busy;
    logic             eff_done;
    logic [6:0]       eff_pct;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P / 2) clk = ~clk;

    vgate_pipe #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .ds_stall(ds_stall), .out_valid(out_valid),
        .out_data(out_data), .stall_gates(stall_gates), .stage_en(stage_en),
        .cnt_clr(cnt_clr), .en_cnt(en_cnt), .tot_cnt(tot_cnt),
        .eff_req(eff_req), .eff_busy(eff_busy), .eff_done(eff_done),
        .eff_pct(eff_pct)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int k = 0; k < n; k++) step();
    endtask

    // Request a result and wait for the done pulse; returns the percentage.
    task automatic run_eff(output logic [6:0] res, output bit seen);
        eff_req = 1'b1;
        step();
        eff_req = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 100 && !seen; k++) begin
            if (eff_done) seen = 1'b1;
            else step();
        end
        res = eff_pct;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [6:0] pct;
        bit seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 in_ready", in_ready, 1);
        chk("R1 stage_en", stage_en, 0);
        chk("R1 en_cnt", en_cnt, 0);
        chk("R1 tot_cnt", tot_cnt, 0);
        chk("R1 eff_pct", eff_pct, 0);

        // R2 / R10 flow table
        for (int r = 0; r < NROW; r++) begin
            in_valid = FLOW[r][17];
            in_data  = {24'd0, FLOW[r][16:9]};
            step();
            chk("R2 flow out_valid", out_valid, FLOW[r][8]);
            chk("R10 flow out_data", out_data, {24'd0, FLOW[r][7:0]});
        end

        // R4 R5 R6: fill under stall in recirculate mode
        idle(5);
        ds_stall = 1'b1;
        stall_gates = 1'b0;
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b1;
            in_data  = 32'hA0 + k;
            step();
        end
        in_valid = 1'b0;
        #1;
        chk("R5 full refuses input", in_ready, 0);
        chk("R6 recirculate enables all", stage_en, 4'hF);
        chk("R4 out word", out_data, 32'hA0);
        step();
        step();
        chk("R4 held word", out_data, 32'hA0);
        chk("R4 held valid", out_valid, 1);
        stall_gates = 1'b1;
        #1;
        chk("R6 gated disables all", stage_en, 4'h0);
        step();
        chk("R4 gated held word", out_data, 32'hA0);
        ds_stall = 1'b0;
        step();
        chk("R2 release order 1", out_data, 32'hA1);
        step();
        chk("R2 release order 2", out_data, 32'hA2);
        step();
        chk("R2 release order 3", out_data, 32'hA3);
        step();
        chk("R10 empty out_valid", out_valid, 0);
        chk("R10 empty keeps word", out_data, 32'hA3);

        // R5 bubble collapse behind a blocked tail
        ds_stall = 1'b1;
        in_valid = 1'b1;
        in_data  = 32'h55;
        step();
        idle(3);
        chk("R5 lone tail word", out_data, 32'h55);
        #1;
        chk("R5 ready with bubbles", in_ready, 1);
        chk("R3 gated idle stage_en", stage_en, 4'h0);
        in_valid = 1'b1;
        in_data  = 32'h66;
        step();
        idle(2);
        ds_stall = 1'b0;
        step();
        chk("R5 squeezed word next", out_data, 32'h66);
        chk("R5 squeezed valid", out_valid, 1);
        step();
        chk("R5 then empty", out_valid, 0);

        // R7 R8 R9 counting over a known pattern
        stall_gates = 1'b0;
        idle(5);
        cnt_clr = 1'b1;
        step();
        cnt_clr = 1'b0;
        chk("R8 clear en", en_cnt, 0);
        chk("R8 clear tot", tot_cnt, 0);
        in_valid = 1'b1;
        in_data  = 32'h1;
        #1;
        chk("R3 head enable", stage_en, 4'h1);
        for (int k = 0; k < 5; k++) step();
        idle(5);
        chk("R7 en count", en_cnt, 20);
        chk("R7 tot count", tot_cnt, 40);
        eff_req = 1'b1;
        step();
        eff_req = 1'b0;
        chk("R9 busy after request", eff_busy, 1);
        step();
        step();
        eff_req = 1'b1;
        step();
        eff_req = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 100 && !seen; k++) begin
            if (eff_done) seen = 1'b1;
            else step();
        end
        chk("R9 done seen", seen, 1);
        chk("R9 pct half", eff_pct, 50);
        step();
        chk("R9 second request ignored", eff_busy, 0);
        chk("R9 done single pulse", eff_done, 0);

        // R9 all idle gives 100
        cnt_clr = 1'b1;
        step();
        cnt_clr = 1'b0;
        idle(5);
        run_eff(pct, seen);
        chk("R9 idle done", seen, 1);
        chk("R9 idle pct", pct, 100);

        // R9 zero denominator gives 0
        cnt_clr = 1'b1;
        step();
        run_eff(pct, seen);
        cnt_clr = 1'b0;
        chk("R9 zero done", seen, 1);
        chk("R9 zero pct", pct, 0);

        // R7 saturation
        cnt_clr = 1'b1;
        step();
        cnt_clr = 1'b0;
        idle(1100);
        chk("R7 tot saturates", tot_cnt, CMAX);
        chk("R7 en stays zero", en_cnt, 0);
        run_eff(pct, seen);
        chk("R9 saturated pct", pct, 100);

        // R1 reset in mid-flight
        in_valid = 1'b1;
        in_data  = 32'h77;
        for (int k = 0; k < 4; k++) step();
        rst_n = 1'b0;
        in_valid = 1'b0;
        step();
        rst_n = 1'b1;
        #1;
        chk("R1 mid reset out_valid", out_valid, 0);
        chk("R1 mid reset tot", tot_cnt, 0);
        chk("R1 mid reset ready", in_ready, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule